// File: doc/BRIEF.md
# SD Host Register View Bridge

This block sits between a host-side register bus that expects the standard SD host controller register layout and a vendor controller core whose bits have been moved, widened or merged. The host issues 8-, 16- or 32-bit accesses at byte offsets. The bridge turns each access into one or more 32-bit word accesses on the backend and translates the fields in both directions, so that software written for the standard layout runs unchanged.

Several registers are handled specially. The host-control byte is rebuilt from the vendor's wider protocol word. The present-state word is repacked. The slot interrupt status and the power-control byte are synthesized inside the bridge. The transfer-mode halfword is handled in one of two ways, chosen by a parameter. In the merged variant it is held locally, and a later command write issues both halves as one word. In the split variant it lives in a separate mixed-control word, and the version register reads as spec 3.0. Any other sub-word write becomes a read-modify-write of the aligned word.

The host holds a request for one cycle and then waits for a one-cycle ready pulse. Toward the backend the bridge raises a request and holds it stable until the backend acknowledges.

Top module: `sdreg_bridge`

## Requirements
- R1: After reset, h_ready and be_req are low and h_rdata is zero.
- R2: A read at any offset not listed below fetches the aligned word. It returns the byte or halfword selected by the low two address bits (size code 0 = byte, 1 = halfword, 2 = word), zero-extended into the low bits of h_rdata.
- R3: A byte or halfword write at an unlisted offset reads the aligned word, replaces only the addressed lane and writes the word back. A word write is a single backend write with no read.
- R4: A word read at offset 0x24 returns (vendor & 0x000F0F07) | ((vendor >> 4) & 0x00F00000) | ((vendor >> 9) & 0x8).
- R5: A byte read at 0x28 returns vendor bits 7, 6 and 0 in place. The vendor width field [2:1] maps as 1 → 0x02, 2 → 0x20, otherwise 0. The vendor DMA field [9:8] maps as 2 → 0x10, 3 → 0x18, 0 or 1 → 0.
- R6: A byte write at 0x28 clears vendor bits 0, 2:1, 7:6 and 9:8, keeps all other vendor bits, and then inserts the new values. Bit 0 and bits 7:6 are copied. The width field becomes 2 if host bit 5 is set, else 1 if host bit 1 is set, else 0. Host bits 4:3 go to vendor bits 9:8.
- R7: A byte read at 0x29 returns 0x0D. A byte write at 0x29 causes no backend access and changes nothing.
- R8: In the merged variant, a halfword write at 0x0C is held locally with no backend access. A halfword write at 0x0E issues one word write to 0x0C carrying the command in bits 31:16 and the held mode in bits 15:0. Halfword reads of 0x0C and 0x0E return the held values.
- R9: In the split variant, halfword reads at 0x0C return word 0x48 & 0x37. Halfword writes at 0x0C set word 0x48 to (old with bits 5:0 cleared) | (value & 0x37). A halfword read at 0xFE returns 0x0002.
- R10: A halfword read at 0xFC returns 1 if (word 0x30 & word 0x38) is non-zero, and 0 otherwise.
- R11: be_req, be_we, be_addr and be_wdata stay stable until be_ack. Each accepted host request yields exactly one single-cycle h_ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access request, one cycle, only while idle |
| h_we | input | 1 | Host write when high |
| h_size | input | 2 | 0 byte, 1 halfword, 2 word |
| h_addr | input | ADDR_W | Host byte offset |
| h_wdata | input | 32 | Host write value, right-aligned |
| h_ready | output | 1 | Access complete pulse |
| h_rdata | output | 32 | Read value, right-aligned, valid with h_ready |
| be_req | output | 1 | Backend word request |
| be_we | output | 1 | Backend write when high |
| be_addr | output | ADDR_W | Backend word-aligned byte address |
| be_wdata | output | 32 | Backend write word |
| be_ack | input | 1 | Backend completion |
| be_rdata | input | 32 | Backend read word, valid with be_ack |

## Verification
The bench targets the lane arithmetic of read-modify-write. A design that shifted by the wrong lane, or did not mask the old lane, would corrupt neighbouring bytes of the word read back afterwards. For the host-control byte, it writes bit 5 and bit 1 together to prove that 8-bit wins, and it reads vendor DMA code 1 and width code 3, which must both appear as zero. A design that leaked vendor bits 3 to 5 through the clear mask would show them in the word read back. It checks that power and held-mode writes leave the backend write count untouched, and that a command write merges the earlier mode into one word. A swapped half or a stale cache would show in the stored word. The slot status is driven from 0 to 1 by changing only the enable word, which catches a design that tests one register alone.

// File: rtl/sdreg_pkg.sv
package sdreg_pkg;
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  localparam logic [7:0] OFF_XFER  = 8'h0C;
  localparam logic [7:0] OFF_CMD   = 8'h0E;
  localparam logic [7:0] OFF_PRES  = 8'h24;
  localparam logic [7:0] OFF_HCTL  = 8'h28;
  localparam logic [7:0] OFF_PWR   = 8'h29;
  localparam logic [7:0] OFF_IRQ   = 8'h30;
  localparam logic [7:0] OFF_SIGEN = 8'h38;
  localparam logic [7:0] OFF_MIX   = 8'h48;
  localparam logic [7:0] OFF_SLOT  = 8'hFC;
  localparam logic [7:0] OFF_VER   = 8'hFE;

  localparam logic [31:0] PRES_KEEP = 32'h000F0F07;
  localparam logic [31:0] HCTL_CLR  = 32'h000003C7;
  localparam logic [7:0]  HCTL_PASS = 8'hC1;
  localparam logic [31:0] MIX_MASK  = 32'h00000037;
  localparam logic [7:0]  PWR_VAL   = 8'h0D;
  localparam logic [15:0] VER_VAL   = 16'h0002;

  typedef enum logic [2:0] {K_GEN, K_HCTL, K_PRES, K_MIX, K_SLOT} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_RESP} state_e;
endpackage

// File: rtl/sdreg_lane.sv
module sdreg_lane
  import sdreg_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  off,
  input  logic [1:0]  size,
  input  logic [31:0] val,
  output logic [31:0] ext,
  output logic [31:0] ins
);
  logic [4:0]  sh;
  logic [31:0] mask;
  logic [31:0] shifted;

  always_comb begin
    sh      = {off, 3'b000};
    mask    = (size == SZ_B) ? 32'h000000FF :
              (size == SZ_H) ? 32'h0000FFFF : 32'hFFFFFFFF;
    shifted = word >> sh;
    ext     = (size == SZ_W) ? word : (shifted & mask);
    ins     = (word & ~(mask << sh)) | ((val & mask) << sh);
  end
endmodule

// File: rtl/sdreg_fieldmap.sv
module sdreg_fieldmap
  import sdreg_pkg::*;
(
  input  logic [31:0] vend,
  input  logic [7:0]  hb,
  output logic [7:0]  hctl_rd,
  output logic [31:0] hctl_wr,
  output logic [31:0] pres_rd
);
  logic [7:0]  wbits, dbits;
  logic [31:0] ins;
  logic        unused_hb;

  assign unused_hb = hb[2];

  always_comb begin
    case (vend[2:1])
      2'd1:    wbits = 8'h02;
      2'd2:    wbits = 8'h20;
      default: wbits = 8'h00;
    endcase
    case (vend[9:8])
      2'd2:    dbits = 8'h10;
      2'd3:    dbits = 8'h18;
      default: dbits = 8'h00;
    endcase
    hctl_rd = (vend[7:0] & HCTL_PASS) | wbits | dbits;

    ins      = '0;
    ins[0]   = hb[0];
    ins[2:1] = hb[5] ? 2'd2 : (hb[1] ? 2'd1 : 2'd0);
    ins[7:6] = hb[7:6];
    ins[9:8] = hb[4:3];
    hctl_wr  = (vend & ~HCTL_CLR) | ins;

    pres_rd = (vend & PRES_KEEP) | ((vend >> 4) & 32'h00F00000) |
              ((vend >> 9) & 32'h00000008);
  end
endmodule

// File: rtl/sdreg_bridge.sv
module sdreg_bridge
  import sdreg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit MERGED_CMD = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [1:0]        h_size,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic              h_ready,
  output logic [31:0]       h_rdata,
  output logic              be_req,
  output logic              be_we,
  output logic [ADDR_W-1:0] be_addr,
  output logic [31:0]       be_wdata,
  input  logic              be_ack,
  input  logic [31:0]       be_rdata
);
  localparam logic [ADDR_W-1:0] A_XFER  = ADDR_W'(OFF_XFER);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_PRES  = ADDR_W'(OFF_PRES);
  localparam logic [ADDR_W-1:0] A_HCTL  = ADDR_W'(OFF_HCTL);
  localparam logic [ADDR_W-1:0] A_PWR   = ADDR_W'(OFF_PWR);
  localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(OFF_IRQ);
  localparam logic [ADDR_W-1:0] A_SIGEN = ADDR_W'(OFF_SIGEN);
  localparam logic [ADDR_W-1:0] A_MIX   = ADDR_W'(OFF_MIX);
  localparam logic [ADDR_W-1:0] A_SLOT  = ADDR_W'(OFF_SLOT);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFF_VER);

  state_e            state;
  kind_e             kind_q;
  logic              rmw_q, slot2_q;
  logic [ADDR_W-1:0] a_q;
  logic [1:0]        sz_q;
  logic [31:0]       wd_q, first_q, cache_q;
  logic [31:0]       lane_ext, lane_ins, hctl_wr, pres_rd;
  logic [7:0]        hctl_rd;
  logic [31:0]       nw, rd_x;
  logic              acc, is_pwr, is_hctl, is_pres, is_slot, is_xfer, is_cmd, is_ver;
  logic [ADDR_W-1:0] aligned;

  assign h_ready = (state == S_RESP);
  assign acc     = (state == S_IDLE) && h_req;
  assign aligned = {h_addr[ADDR_W-1:2], 2'b00};
  assign is_pwr  = (h_size == SZ_B) && (h_addr == A_PWR);
  assign is_hctl = (h_size == SZ_B) && (h_addr == A_HCTL);
  assign is_pres = (h_size == SZ_W) && (h_addr == A_PRES) && !h_we;
  assign is_slot = (h_size == SZ_H) && (h_addr == A_SLOT) && !h_we;
  assign is_xfer = (h_size == SZ_H) && (h_addr == A_XFER);
  assign is_cmd  = (h_size == SZ_H) && (h_addr == A_CMD);
  assign is_ver  = (h_size == SZ_H) && (h_addr == A_VER) && !h_we;

  sdreg_lane u_lane (
    .word(be_rdata), .off(a_q[1:0]), .size(sz_q), .val(wd_q),
    .ext(lane_ext), .ins(lane_ins)
  );

  sdreg_fieldmap u_map (
    .vend(be_rdata), .hb(wd_q[7:0]),
    .hctl_rd(hctl_rd), .hctl_wr(hctl_wr), .pres_rd(pres_rd)
  );

  generate
    if (MERGED_CMD) begin : g_cache
      always_ff @(posedge clk) begin
        if (rst) cache_q <= '0;
        else if (acc && h_we && is_xfer) cache_q[15:0]  <= h_wdata[15:0];
        else if (acc && h_we && is_cmd)  cache_q[31:16] <= h_wdata[15:0];
      end
    end else begin : g_nocache
      assign cache_q = '0;
    end
  endgenerate

  always_comb begin
    case (kind_q)
      K_HCTL:  begin nw = hctl_wr; rd_x = {24'h0, hctl_rd}; end
      K_PRES:  begin nw = lane_ins; rd_x = pres_rd; end
      K_MIX:   begin nw = {be_rdata[31:6], 6'b0} | (wd_q & MIX_MASK);
                     rd_x = be_rdata & MIX_MASK; end
      default: begin nw = lane_ins; rd_x = lane_ext; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; kind_q <= K_GEN; rmw_q <= 1'b0; slot2_q <= 1'b0;
      a_q <= '0; sz_q <= '0; wd_q <= '0; first_q <= '0; h_rdata <= '0;
      be_req <= 1'b0; be_we <= 1'b0; be_addr <= '0; be_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (h_req) begin
          a_q <= h_addr; sz_q <= h_size; wd_q <= h_wdata;
          kind_q <= K_GEN; rmw_q <= h_we; slot2_q <= 1'b0; h_rdata <= '0;
          if (is_pwr) begin
            h_rdata <= h_we ? 32'h0 : {24'h0, PWR_VAL};
            state   <= S_RESP;
          end else if (MERGED_CMD && (is_xfer || is_cmd)) begin
            if (!h_we) begin
              h_rdata <= is_xfer ? {16'h0, cache_q[15:0]} : {16'h0, cache_q[31:16]};
              state   <= S_RESP;
            end else if (is_xfer) begin
              state <= S_RESP;
            end else begin
              be_req <= 1'b1; be_we <= 1'b1; be_addr <= A_XFER;
              be_wdata <= {h_wdata[15:0], cache_q[15:0]};
              state <= S_WR;
            end
          end else if (!MERGED_CMD && is_ver) begin
            h_rdata <= {16'h0, VER_VAL};
            state   <= S_RESP;
          end else begin
            be_req <= 1'b1;
            be_we  <= 1'b0;
            state  <= S_RD;
            if (!MERGED_CMD && is_xfer) begin
              kind_q <= K_MIX; be_addr <= A_MIX;
            end else if (is_slot) begin
              kind_q <= K_SLOT; be_addr <= A_IRQ;
            end else if (is_hctl) begin
              kind_q <= K_HCTL; be_addr <= A_HCTL;
            end else if (is_pres) begin
              kind_q <= K_PRES; be_addr <= A_PRES;
            end else if (h_we && h_size == SZ_W) begin
              be_we <= 1'b1; be_addr <= aligned; be_wdata <= h_wdata;
              state <= S_WR;
            end else begin
              be_addr <= aligned;
            end
          end
        end
        S_RD: if (be_ack) begin
          if (kind_q == K_SLOT) begin
            if (!slot2_q) begin
              first_q <= be_rdata; slot2_q <= 1'b1; be_addr <= A_SIGEN;
            end else begin
              h_rdata <= {31'h0, |(first_q & be_rdata)};
              be_req  <= 1'b0;
              state   <= S_RESP;
            end
          end else if (rmw_q) begin
            be_we <= 1'b1; be_wdata <= nw; state <= S_WR;
          end else begin
            h_rdata <= rd_x; be_req <= 1'b0; state <= S_RESP;
          end
        end
        S_WR: if (be_ack) begin
          be_req <= 1'b0; be_we <= 1'b0; state <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: backend request fields held until acknowledged
  a_r11_be_hold: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> (be_req && $stable(be_addr) && $stable(be_we) && $stable(be_wdata)));

  // R11: ready is a single-cycle pulse
  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    h_ready |=> !h_ready);

  // R7: a power-control write never reaches the backend
  a_r7_pwr_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc && h_we && is_pwr) |=> (!be_req && h_ready));

  // R8: a held transfer-mode write never reaches the backend
  a_r8_mode_held: assert property (@(posedge clk) disable iff (rst)
    (MERGED_CMD && acc && h_we && is_xfer) |=> (!be_req && h_ready));

  // R10: slot status answer is a single bit
  a_r10_slot_bit: assert property (@(posedge clk) disable iff (rst)
    (h_ready && kind_q == K_SLOT) |-> (h_rdata[31:1] == 31'h0));
endmodule

// File: tb/sim_sdreg_bridge.sv
module sim_be #(parameter int LAT = 1) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  input  logic        pl_en,
  input  logic [5:0]  pl_idx,
  input  logic [31:0] pl_data,
  output int          wr_cnt,
  output int          rd_cnt
);
  logic [31:0] mem [64];
  logic [2:0]  cnt;
  logic        fire;
  assign fire = req && !ack && (cnt == 3'(LAT));

  always_ff @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_data;
    else if (fire && we) mem[addr[7:2]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0; cnt <= '0; rdata <= '0; wr_cnt <= 0; rd_cnt <= 0;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (fire) begin
          ack <= 1'b1; cnt <= '0;
          if (we) wr_cnt <= wr_cnt + 1;
          else begin rdata <= mem[addr[7:2]]; rd_cnt <= rd_cnt + 1; end
        end else cnt <= cnt + 3'd1;
      end
    end
  end
endmodule

module sim_sdreg_bridge;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, issued = 0, pulses = 0;

  logic h0_req = 0, h0_we = 0, h1_req = 0, h1_we = 0;
  logic [1:0] h0_sz = 0, h1_sz = 0;
  logic [7:0] h0_ad = 0, h1_ad = 0;
  logic [31:0] h0_wd = 0, h1_wd = 0;
  logic h0_ready, h1_ready;
  logic [31:0] h0_rd, h1_rd;
  logic b0_req, b0_we, b0_ack, b1_req, b1_we, b1_ack;
  logic [7:0] b0_ad, b1_ad;
  logic [31:0] b0_wd, b0_rd, b1_wd, b1_rd;
  logic pl0 = 0, pl1 = 0;
  logic [5:0] pli = 0;
  logic [31:0] pld = 0;
  int wc0, rc0, wc1, rc1;

  sdreg_bridge #(.ADDR_W(8), .MERGED_CMD(1'b1)) u0 (
    .clk(clk), .rst(rst), .h_req(h0_req), .h_we(h0_we), .h_size(h0_sz),
    .h_addr(h0_ad), .h_wdata(h0_wd), .h_ready(h0_ready), .h_rdata(h0_rd),
    .be_req(b0_req), .be_we(b0_we), .be_addr(b0_ad), .be_wdata(b0_wd),
    .be_ack(b0_ack), .be_rdata(b0_rd));

  sdreg_bridge #(.ADDR_W(8), .MERGED_CMD(1'b0)) u1 (
    .clk(clk), .rst(rst), .h_req(h1_req), .h_we(h1_we), .h_size(h1_sz),
    .h_addr(h1_ad), .h_wdata(h1_wd), .h_ready(h1_ready), .h_rdata(h1_rd),
    .be_req(b1_req), .be_we(b1_we), .be_addr(b1_ad), .be_wdata(b1_wd),
    .be_ack(b1_ack), .be_rdata(b1_rd));

  sim_be #(.LAT(1)) m0 (.clk(clk), .rst(rst), .req(b0_req), .we(b0_we), .addr(b0_ad),
    .wdata(b0_wd), .ack(b0_ack), .rdata(b0_rd), .pl_en(pl0), .pl_idx(pli),
    .pl_data(pld), .wr_cnt(wc0), .rd_cnt(rc0));
  sim_be #(.LAT(2)) m1 (.clk(clk), .rst(rst), .req(b1_req), .we(b1_we), .addr(b1_ad),
    .wdata(b1_wd), .ack(b1_ack), .rdata(b1_rd), .pl_en(pl1), .pl_idx(pli),
    .pl_data(pld), .wr_cnt(wc1), .rd_cnt(rc1));

  bit          qc [$];
  logic [31:0] qv [$];
  string       qt [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && (h0_ready || h1_ready)) begin
      pulses++;
      if (qc.size() == 0) chk(1'b0, "R11 unexpected ready", 32'h1, 32'h0);
      else begin
        bit c; logic [31:0] v; string t; logic [31:0] a;
        c = qc.pop_front(); v = qv.pop_front(); t = qt.pop_front();
        a = h0_ready ? h0_rd : h1_rd;
        if (c) chk(a === v, t, a, v);
      end
    end
  end

  task automatic preload(input int d, input logic [7:0] ad, input logic [31:0] v);
    @(negedge clk);
    pli = ad[7:2]; pld = v;
    if (d == 0) pl0 = 1; else pl1 = 1;
    @(negedge clk);
    pl0 = 0; pl1 = 0;
  endtask

  task automatic acc(input int d, input logic we, input logic [1:0] sz, input logic [7:0] ad,
                     input logic [31:0] wd, input logic [31:0] exp, input string tag);
    qc.push_back(!we); qv.push_back(exp); qt.push_back(tag);
    issued++;
    @(negedge clk);
    if (d == 0) begin h0_req = 1; h0_we = we; h0_sz = sz; h0_ad = ad; h0_wd = wd; end
    else        begin h1_req = 1; h1_we = we; h1_sz = sz; h1_ad = ad; h1_wd = wd; end
    @(negedge clk);
    h0_req = 0; h1_req = 0;
    while (!((d == 0) ? h0_ready : h1_ready)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w, r;
    preload(0, 8'h0C, 32'hFFFFFFFF);
    preload(0, 8'h24, 32'h3C0F1F07);
    preload(0, 8'h28, 32'h00000245);
    preload(0, 8'h30, 32'h00000010);
    preload(0, 8'h38, 32'h00000001);
    preload(0, 8'h40, 32'hDEADBEEF);
    preload(0, 8'hFC, 32'h77660000);
    preload(1, 8'h0C, 32'h00005555);
    preload(1, 8'h48, 32'hAAAA00FF);
    preload(1, 8'h24, 32'h0500E0F0);
    preload(1, 8'h28, 32'h00000106);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(!h0_ready && !b0_req && h0_rd == 0 && !h1_ready && !b1_req, "R1 reset state",
        {h0_ready, b0_req, h1_ready, b1_req}, 32'h0);

    acc(0, 0, 2, 8'h24, 0, 32'h00CF0F0F, "R4 present state with retune");
    acc(1, 0, 2, 8'h24, 0, 32'h00500000, "R4 present state masked bits");
    acc(0, 0, 0, 8'h28, 0, 32'h00000071, "R5 hostctl 8bit adma2");
    acc(1, 0, 0, 8'h28, 0, 32'h00000000, "R5 hostctl code1 dma width3");
    acc(0, 1, 2, 8'h28, 32'h12340382, 0, "");
    acc(0, 0, 0, 8'h28, 0, 32'h0000009A, "R5 hostctl 4bit adma64");
    acc(0, 0, 0, 8'h2B, 0, 32'h00000012, "R2 byte lane 3 of hostctl word");
    acc(0, 1, 2, 8'h28, 32'h12340392, 0, "");
    acc(0, 1, 0, 8'h28, 32'h0000003A, 0, "");
    acc(0, 0, 2, 8'h28, 0, 32'h12340314, "R6 8bit priority and dma insert");
    acc(0, 0, 0, 8'h28, 0, 32'h00000038, "R5 R6 readback");
    acc(0, 1, 0, 8'h28, 32'h000000C3, 0, "");
    acc(0, 0, 2, 8'h28, 0, 32'h123400D3, "R6 led 4bit and card detect bits");

    acc(0, 0, 0, 8'h29, 0, 32'h0000000D, "R7 power read");
    w = wc0;
    acc(0, 1, 0, 8'h29, 32'h000000FF, 0, "");
    chk(wc0 == w, "R7 power write no backend", wc0, w);
    acc(0, 0, 2, 8'h28, 0, 32'h123400D3, "R7 word unchanged after power write");

    acc(0, 0, 0, 8'h41, 0, 32'h000000BE, "R2 byte lane 1");
    acc(0, 0, 1, 8'h42, 0, 32'h0000DEAD, "R2 upper half");
    acc(0, 0, 2, 8'h40, 0, 32'hDEADBEEF, "R2 full word");
    acc(0, 1, 0, 8'h43, 32'h0000005A, 0, "");
    acc(0, 1, 1, 8'h40, 32'h00001234, 0, "");
    acc(0, 0, 2, 8'h40, 0, 32'h5AAD1234, "R3 byte and half rmw");
    w = wc0; r = rc0;
    acc(0, 1, 2, 8'h44, 32'hCAFEF00D, 0, "");
    chk(wc0 == w + 1 && rc0 == r, "R3 word write single access", wc0 - w, 1);
    chk(m0.mem[6'h11] == 32'hCAFEF00D, "R3 word write stored", m0.mem[6'h11], 32'hCAFEF00D);

    w = wc0; r = rc0;
    acc(0, 1, 1, 8'h0C, 32'h00000023, 0, "");
    chk(wc0 == w && rc0 == r, "R8 mode write held", wc0 - w, 0);
    acc(0, 0, 1, 8'h0C, 0, 32'h00000023, "R8 mode readback");
    acc(0, 1, 1, 8'h0E, 32'h00000C1A, 0, "");
    chk(wc0 == w + 1, "R8 one merged write", wc0 - w, 1);
    chk(m0.mem[6'h03] == 32'h0C1A0023, "R8 merged word", m0.mem[6'h03], 32'h0C1A0023);
    acc(0, 0, 1, 8'h0E, 0, 32'h00000C1A, "R8 command readback");
    acc(0, 0, 1, 8'hFE, 0, 32'h00007766, "R2 version offset generic when merged");

    acc(0, 0, 1, 8'hFC, 0, 32'h00000000, "R10 slot status clear");
    acc(0, 1, 2, 8'h38, 32'h00000011, 0, "");
    acc(0, 0, 1, 8'hFC, 0, 32'h00000001, "R10 slot status set");

    acc(1, 0, 1, 8'h0C, 0, 32'h00000037, "R9 mode read masked");
    acc(1, 1, 1, 8'h0C, 32'h000000FF, 0, "");
    chk(m1.mem[6'h12] == 32'hAAAA00F7, "R9 mode write clears low six", m1.mem[6'h12], 32'hAAAA00F7);
    acc(1, 1, 1, 8'h0C, 32'h00000012, 0, "");
    acc(1, 0, 1, 8'h0C, 0, 32'h00000012, "R9 mode readback");
    acc(1, 0, 1, 8'hFE, 0, 32'h00000002, "R9 version");
    acc(1, 1, 1, 8'h0E, 32'h00001234, 0, "");
    chk(m1.mem[6'h03] == 32'h12345555, "R3 split variant command rmw", m1.mem[6'h03], 32'h12345555);

    repeat (3) @(negedge clk);
    chk(pulses == issued && qc.size() == 0, "R11 one ready per request", pulses, issued);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule